// File: doc/BRIEF.md
# Parallel Port Register Decoder

This block is the host-facing register front end of a controller with three 8-bit parallel ports. A host drives chip select, a two-bit address, a data byte and active-low read and write strobes. The block turns these into writes to the three port output latches or to a write-only configuration register. On reads, it returns one port's value on a data bus that it enables only when a valid register is read.

A write to the configuration address carries one of two command formats, chosen by its top bit. A definition word sets the mode and direction of every port and clears all output latches. A single-bit command sets or clears one port C latch bit and leaves the stored definition as it was. Port C is split into two nibbles whose directions are set independently. The block drives per-pin output enables, the port latches and the decoded mode fields to the pad and handshake logic that sits around it.

Write strobes arrive from an asynchronous host. The block samples them on the system clock and commits a write after it sees the strobe return high. Reads are combinational from the pins, the latches and the direction bits.

Top module: `ppio_regif`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block clears every output latch and both mode fields. It forces all three ports to input, so every output enable is 0.
- R2: With `cs_n` low, `addr` = 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register, for both reads and writes.
- R3: A write made while `cs_n` was high changes nothing. A read with `cs_n` high leaves `dout_oe` at 0.
- R4: A read at `addr` = 3 never returns the configuration, and `dout_oe` stays 0.
- R5: A configuration write with bit 7 = 1 stores the port modes and directions. Bits 6:5 give the port A mode, bit 4 the port A direction, bit 3 the port C upper-nibble direction, bit 2 the port B mode, bit 1 the port B direction and bit 0 the port C lower-nibble direction. A direction bit of 1 means input, so that port's output enables go to 0.
- R6: A definition word (bit 7 = 1) clears the port A, B and C output latches to zero.
- R7: A configuration write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3:1. Bits 6:4 are ignored, and the modes, directions and all other latch bits do not change.
- R8: A write uses the `cs_n`, `addr` and `din` values sampled at the last clock edge with `wr_n` low. It takes effect at the clock edge that follows the first edge at which `wr_n` is sampled high again.
- R9: A read of a port set to input returns its pins. A read of a port set to output returns its latch. Port C does this per nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Drive enable for the host data bus (0 = high impedance) |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |
| mode_a | output | 2 | Stored port A mode |
| mode_b | output | 1 | Stored port B mode |

## Verification
A corrupted direction bit shows on the next read of that port and, at once, on the output-enable pins. A wrong latch bit appears on the port outputs one clock after the commit edge. A bad decode of the command's top bit shows on the same clock edge in two ways: mode fields change after a single-bit command, or latches fail to clear after a definition word. The reference model in the bench predicts every output each clock, so any such divergence is caught within one cycle of the commit.

// File: rtl/ppio_pkg.sv
// Shared types for the parallel port register decoder.
// Assumes 8-bit ports; the configuration layout below is fixed by the host programming model.
package ppio_pkg;

    typedef enum logic [1:0] {
        SEL_PA   = 2'b00,
        SEL_PB   = 2'b01,
        SEL_PC   = 2'b10,
        SEL_CTRL = 2'b11
    } ppio_sel_e;

    // Field order follows bits 6..0 of a definition word.
    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } ppio_cfg_t;

    localparam ppio_cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                        b_mode: 1'b0,  b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppio_wr_sync.sv
// Write strobe synchroniser and capture stage.
// Samples the asynchronous write strobe on clk, holds the select, address and data
// seen at the last edge with the strobe low, and pulses commit one cycle after the
// strobe is first sampled high again. Assumes the host holds address and data stable
// while the strobe is low.
module ppio_wr_sync
    import ppio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic [1:0]   addr,
    input  logic         wr_n,
    input  logic [W-1:0] din,
    output logic         commit,
    output ppio_sel_e    c_addr,
    output logic [W-1:0] c_data
);

    logic wr_s1, wr_s2, cap_sel;

    // Two-stage strobe history for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_s1 <= 1'b1;
            wr_s2 <= 1'b1;
        end else begin
            wr_s1 <= wr_n;
            wr_s2 <= wr_s1;
        end
    end

    // Capture bus fields while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sel <= 1'b0;
            c_addr  <= SEL_PA;
            c_data  <= '0;
        end else if (!wr_n) begin
            cap_sel <= !cs_n;
            c_addr  <= ppio_sel_e'(addr);
            c_data  <= din;
        end
    end

    assign commit = wr_s1 & ~wr_s2 & cap_sel;

    // R8: a commit is a single-cycle pulse.
    a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/ppio_ctrl_regs.sv
// Configuration register and port output latches.
// Applies committed writes: port writes load a latch; configuration writes either
// redefine every port (clearing the latches) or change one port C latch bit.
module ppio_ctrl_regs
    import ppio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  ppio_sel_e    c_addr,
    input  logic [W-1:0] c_data,
    output ppio_cfg_t    cfg,
    output logic [W-1:0] pa_lat,
    output logic [W-1:0] pb_lat,
    output logic [W-1:0] pc_lat
);

    localparam int SEL_W = $clog2(W);
    localparam int CFG_W = $bits(ppio_cfg_t);

    logic ctrl_go, bsr_go, def_go;
    assign ctrl_go = commit && (c_addr == SEL_CTRL);
    assign def_go  = ctrl_go &&  c_data[W-1];
    assign bsr_go  = ctrl_go && !c_data[W-1];

    // Apply a committed write to the latches or the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= CFG_RESET;
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else if (commit) begin
            unique case (c_addr)
                SEL_PA: pa_lat <= c_data;
                SEL_PB: pb_lat <= c_data;
                SEL_PC: pc_lat <= c_data;
                SEL_CTRL: begin
                    if (c_data[W-1]) begin
                        cfg    <= ppio_cfg_t'(c_data[CFG_W-1:0]);
                        pa_lat <= '0;
                        pb_lat <= '0;
                        pc_lat <= '0;
                    end else begin
                        pc_lat[c_data[SEL_W:1]] <= c_data[0];
                    end
                end
            endcase
        end
    end

    // R7: a single-bit command leaves the definition alone.
    a_r7_bsr_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_go |=> $stable(cfg));
    // R7: a single-bit command flips at most one port C bit.
    a_r7_bsr_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_go |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1));
    // R7: ports A and B are untouched by a single-bit command.
    a_r7_bsr_keeps_ab: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_go |=> ($stable(pa_lat) && $stable(pb_lat)));
    // R6: a definition word empties every latch.
    a_r6_def_clears: assert property (@(posedge clk) disable iff (!rst_n)
        def_go |=> (pa_lat == '0 && pb_lat == '0 && pc_lat == '0));
    // R2: port writes never alter the configuration.
    a_r2_port_write_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_addr != SEL_CTRL) |=> $stable(cfg));

endmodule

// File: rtl/ppio_rd_mux.sv
// Host read multiplexer.
// Chooses pin or latch per port (per nibble for port C) from the direction bits and
// enables the host data bus only for a selected read of a port address.
module ppio_rd_mux #(
    parameter int W = 8
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [1:0]   addr,
    input  logic         a_in,
    input  logic         b_in,
    input  logic         cu_in,
    input  logic         cl_in,
    input  logic [W-1:0] pa_in,
    input  logic [W-1:0] pb_in,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] pa_lat,
    input  logic [W-1:0] pb_lat,
    input  logic [W-1:0] pc_lat,
    output logic [W-1:0] dout,
    output logic         dout_oe
);

    localparam int NIB = W / 2;

    logic [W-1:0] pc_view;
    logic [1:0]   nib_in;
    assign nib_in = {cu_in, cl_in};

    // Per-nibble choice of pin or latch for port C.
    for (genvar h = 0; h < 2; h++) begin : g_nib
        assign pc_view[h*NIB +: NIB] = nib_in[h] ? pc_in[h*NIB +: NIB] : pc_lat[h*NIB +: NIB];
    end

    // Select the read source by address.
    always_comb begin
        unique case (addr)
            2'b00:   dout = a_in ? pa_in : pa_lat;
            2'b01:   dout = b_in ? pb_in : pb_lat;
            2'b10:   dout = pc_view;
            default: dout = '0;
        endcase
    end

    assign dout_oe = !cs_n && !rd_n && (addr != 2'b11);

endmodule

// File: rtl/ppio_regif.sv
// Top of the parallel port register decoder.
// Joins the write synchroniser, the configuration/latch registers and the read
// multiplexer, and expands direction bits into per-pin output enables.
module ppio_regif
    import ppio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic [1:0]   addr,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe,
    output logic [1:0]   mode_a,
    output logic         mode_b
);

    localparam int NIB = W / 2;

    logic         commit;
    ppio_sel_e    c_addr;
    logic [W-1:0] c_data;
    ppio_cfg_t    cfg;

    ppio_wr_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_n(wr_n), .din(din),
        .commit(commit), .c_addr(c_addr), .c_data(c_data)
    );

    ppio_ctrl_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr), .c_data(c_data),
        .cfg(cfg), .pa_lat(pa_out), .pb_lat(pb_out), .pc_lat(pc_out)
    );

    ppio_rd_mux #(.W(W)) u_mux (
        .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .a_in(cfg.a_in), .b_in(cfg.b_in), .cu_in(cfg.cu_in), .cl_in(cfg.cl_in),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .pa_lat(pa_out), .pb_lat(pb_out), .pc_lat(pc_out),
        .dout(dout), .dout_oe(dout_oe)
    );

    // Whole-port enables for A and B; nibble-wide enables for C.
    assign pa_oe = {W{~cfg.a_in}};
    assign pb_oe = {W{~cfg.b_in}};
    assign pc_oe = {{NIB{~cfg.cu_in}}, {NIB{~cfg.cl_in}}};
    assign mode_a = cfg.a_mode;
    assign mode_b = cfg.b_mode;

    // R4: the configuration address never drives the host bus.
    a_r4_ctrl_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 2'b11) |-> !dout_oe);
    // R3: a deselected block never drives the host bus.
    a_r3_deselect_float: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);
    // R9: an input port A read returns its pins.
    a_r9_input_reads_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && addr == 2'b00 && pa_oe == '0) |-> (dout == pa_in));

endmodule

// File: tb/ppio_regif_test.sv
`timescale 1ns/1ps
module ppio_regif_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       dout_oe, mode_b;
    logic [1:0] mode_a;

    ppio_regif uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .mode_a(mode_a), .mode_b(mode_b)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit checking = 0;
    bit done = 0;

    // Reference model state.
    int   m_amode, m_bmode;
    bit   m_ain, m_cuin, m_bin, m_clin;
    logic [7:0] m_pa, m_pb, m_pc;
    bit   last_wr, pend, cap_cs;
    logic [1:0] cap_a;
    logic [7:0] cap_d;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_apply();
        case (cap_a)
            2'd0: m_pa = cap_d;
            2'd1: m_pb = cap_d;
            2'd2: m_pc = cap_d;
            default: begin
                if (cap_d[7]) begin
                    m_amode = int'(cap_d[6:5]); m_ain = cap_d[4]; m_cuin = cap_d[3];
                    m_bmode = int'(cap_d[2]);   m_bin = cap_d[1]; m_clin = cap_d[0];
                    m_pa = 0; m_pb = 0; m_pc = 0;
                end else begin
                    m_pc[cap_d[3:1]] = cap_d[0];
                end
            end
        endcase
    endtask

    // Behavioural model: commit one edge after the strobe is seen high (R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_amode = 0; m_bmode = 0;
            m_ain = 1; m_cuin = 1; m_bin = 1; m_clin = 1;
            m_pa = 0; m_pb = 0; m_pc = 0;
            last_wr = 1; pend = 0; cap_cs = 0; cap_a = 0; cap_d = 0;
        end else begin
            if (pend && cap_cs) model_apply();
            pend = wr_n && !last_wr;
            if (!wr_n) begin cap_cs = !cs_n; cap_a = addr; cap_d = din; end
            last_wr = wr_n;
        end
    end

    // Compare every output shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        if (checking) begin
            logic       e_oe;
            logic [7:0] e_rd;
            e_oe = !cs_n && !rd_n && (addr != 2'b11);
            case (addr)
                2'd0: e_rd = m_ain ? pa_in : m_pa;
                2'd1: e_rd = m_bin ? pb_in : m_pb;
                default: e_rd = {m_cuin ? pc_in[7:4] : m_pc[7:4], m_clin ? pc_in[3:0] : m_pc[3:0]};
            endcase
            chk("R3 R4 dout_oe", {7'd0, dout_oe}, {7'd0, e_oe});
            if (e_oe) chk("R2 R9 dout", dout, e_rd);
            chk("R6 R7 R8 pa_out", pa_out, m_pa);
            chk("R6 R7 R8 pb_out", pb_out, m_pb);
            chk("R6 R7 R8 pc_out", pc_out, m_pc);
            chk("R5 pa_oe", pa_oe, {8{~m_ain}});
            chk("R5 pb_oe", pb_oe, {8{~m_bin}});
            chk("R5 pc_oe", pc_oe, {{4{~m_cuin}}, {4{~m_clin}}});
            chk("R5 R7 mode_a", {6'd0, mode_a}, 8'(m_amode));
            chk("R5 R7 mode_b", {7'd0, mode_b}, 8'(m_bmode));
        end
    end

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        cs_n = !sel; addr = a; din = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_rd(input logic [1:0] a, input bit sel);
        @(negedge clk);
        cs_n = !sel; addr = a; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        chk("R1 mode_a", {6'd0, mode_a}, 8'h00);
        checking = 1;

        host_wr(2'd3, 8'h80, 1);           // R5: all outputs, simple mode
        host_wr(2'd0, 8'h5A, 1);           // R2
        host_wr(2'd1, 8'hC3, 1);
        host_wr(2'd2, 8'h96, 1);
        host_rd(2'd0, 1); host_rd(2'd1, 1); host_rd(2'd2, 1);
        host_wr(2'd3, 8'h7B, 1);           // R7: set bit 5, junk in 6:4
        host_wr(2'd3, 8'h02, 1);           // R7: clear bit 1
        host_wr(2'd0, 8'hFF, 0);           // R3: deselected write ignored
        host_rd(2'd0, 0);                  // R3: deselected read floats
        host_rd(2'd3, 1);                  // R4: configuration read floats
        pa_in = 8'h3C; pb_in = 8'hE1; pc_in = 8'h7E;
        host_wr(2'd3, 8'h9B, 1);           // R5 R6: all inputs, latches cleared
        host_rd(2'd0, 1); host_rd(2'd1, 1); host_rd(2'd2, 1); // R9
        host_wr(2'd3, 8'hA5, 1);           // R5: A mode 1 output, C upper out, B mode 1 out, C lower in
        host_wr(2'd2, 8'hA5, 1);
        host_rd(2'd2, 1);                  // R9: split nibbles

        for (int i = 0; i < 400; i++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            if ($urandom_range(0, 1) == 0)
                host_wr(2'($urandom), 8'($urandom), $urandom_range(0, 9) != 0);
            else
                host_rd(2'($urandom), $urandom_range(0, 9) != 0);
        end

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end

endmodule